// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Encoder

This block turns a stream of packet payload bytes into the raw byte sequence that a serial slave shift register sends back to its host. Payload bytes arrive on a valid/ready handshake, each with a start flag and an end flag. The encoder frames every packet with a start character, a channel character and a channel number of zero. It escapes any payload byte that would be mistaken for a control value. It also moves the end-of-packet marker so that it sits just ahead of the final payload byte.

The shift register asks for each byte with a one-cycle request pulse. The encoder answers at that clock edge by loading its registered output byte, which then stays unchanged until the next request. When no packet byte is pending, either between packets or while a packet is waiting for payload, the encoder answers with the idle character. The encoder holds exactly one payload byte. This gives it the one byte of lookahead it needs to know, before sending anything for that byte, whether the byte is the last one. The shift register (most significant bit first, SPI mode 1) and the meaning of the payload are outside this block.

Top module: `pkt_byte_escaper`

## Requirements
- R1: After reset, tx_byte is 0x4A and in_ready is 1.
- R2: A payload byte with in_sop set, accepted while no packet is open, produces 0x7A, 0x7C and then 0x00 on three successive requests, before any payload-derived byte.
- R3: A payload byte of 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D on one request, followed by the byte XOR 0x20 on the next request.
- R4: A payload byte of 0x4A or 0x4D is sent as 0x4D on one request, followed by the byte XOR 0x20 on the next request.
- R5: Any other payload byte is sent unchanged on a single request.
- R6: For the byte flagged in_eop, 0x7B is sent first on its own request. The byte then follows, escaped under R3/R4 if it is a reserved value, and the packet closes.
- R7: A request that finds no pending packet byte returns 0x4A, both between packets and inside an open packet that has run out of payload. An open packet stays open across such idle bytes.
- R8: tx_byte changes only at a clock edge where byte_req is 1.
- R9: in_ready is 0 while a byte is held, and a held byte is not released until its last output byte (including any escape prefix) has been sent.
- R10: A byte arriving without in_sop while no packet is open is dropped: it produces no output and in_ready returns to 1.
- R11: A byte with both in_sop and in_eop set produces 0x7A, 0x7C, 0x00, 0x7B and then the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Encoder can take a payload byte |
| in_data | input | 8 | Payload byte |
| in_sop | input | 1 | Byte opens a packet |
| in_eop | input | 1 | Byte closes a packet |
| byte_req | input | 1 | Shift register wants the next output byte |
| tx_byte | output | 8 | Registered byte for the shift register |

## Verification
The bench sends every reserved value, plus nearby non-reserved values, through the middle of a packet. A design that escaped with the wrong prefix, or forgot the XOR, would show the wrong byte pair. It also checks a final byte that is itself reserved and a one-byte packet. A design that emitted the end marker after the byte, or escaped the marker instead of the byte, would misorder the tail. Further checks cover running out of payload inside a packet, where a broken design would close the packet or repeat a stale byte instead of sending idle. They also cover a stray byte with no start flag, which a broken design would frame or let block the input. Finally, in_ready is watched while an escape prefix is in flight, which catches early release of the held byte.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t START_CH    = 8'h7A;
  localparam byte_t END_CH      = 8'h7B;
  localparam byte_t CHAN_CH     = 8'h7C;
  localparam byte_t PKT_ESC_CH  = 8'h7D;
  localparam byte_t IDLE_CH     = 8'h4A;
  localparam byte_t LINK_ESC_CH = 8'h4D;
  localparam byte_t FLIP_MASK   = 8'h20;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CHAN, PH_CHNUM, PH_BODY, PH_ESCB
  } phase_t;

  function automatic logic is_pkt_rsvd(byte_t b);
    return (b == START_CH) || (b == END_CH) || (b == CHAN_CH) || (b == PKT_ESC_CH);
  endfunction

  function automatic logic is_link_rsvd(byte_t b);
    return (b == IDLE_CH) || (b == LINK_ESC_CH);
  endfunction
endpackage

// File: rtl/pbe_hold.sv
module pbe_hold
  import pbe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  byte_t in_data,
  input  logic  in_sop,
  input  logic  in_eop,
  input  logic  release_i,
  output logic  in_ready,
  output logic  cur_valid,
  output byte_t cur_data,
  output logic  cur_sop,
  output logic  cur_eop
);
  assign in_ready = !cur_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur_data  <= '0;
      cur_sop   <= 1'b0;
      cur_eop   <= 1'b0;
    end else if (release_i) begin
      cur_valid <= 1'b0;
    end else if (in_valid && !cur_valid) begin
      cur_valid <= 1'b1;
      cur_data  <= in_data;
      cur_sop   <= in_sop;
      cur_eop   <= in_eop;
    end
  end

  // R9: an offered byte is captured once the slot is free
  assert_hold_load_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> cur_valid);
  // R9: a held byte stays put until the encoder releases it
  assert_hold_keep_R9: assert property (@(posedge clk) disable iff (rst)
    cur_valid && !release_i |=> cur_valid && $stable(cur_data));
endmodule

// File: rtl/pbe_fsm.sv
module pbe_fsm
  import pbe_pkg::*;
#(
  parameter byte_t CHAN_NUM = 8'h00
)(
  input  logic  clk,
  input  logic  rst,
  input  logic  byte_req,
  input  logic  cur_valid,
  input  byte_t cur_data,
  input  logic  cur_sop,
  input  logic  cur_eop,
  output logic  release_o,
  output byte_t tx_byte
);
  phase_t phase, nxt_phase;
  logic   end_sent, nxt_end_sent;
  byte_t  tx_q, nxt_tx;
  logic   pkt_rsvd, link_rsvd;

  assign pkt_rsvd  = is_pkt_rsvd(cur_data);
  assign link_rsvd = is_link_rsvd(cur_data);
  assign tx_byte   = tx_q;

  always_comb begin
    nxt_phase    = phase;
    nxt_end_sent = end_sent;
    nxt_tx       = tx_q;
    release_o    = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (cur_valid && !cur_sop) release_o = 1'b1;
        if (byte_req) begin
          if (cur_valid && cur_sop) begin
            nxt_tx    = START_CH;
            nxt_phase = PH_CHAN;
          end else begin
            nxt_tx = IDLE_CH;
          end
        end
      end
      PH_CHAN: if (byte_req) begin
        nxt_tx    = CHAN_CH;
        nxt_phase = PH_CHNUM;
      end
      PH_CHNUM: if (byte_req) begin
        nxt_tx    = CHAN_NUM;
        nxt_phase = PH_BODY;
      end
      PH_BODY: if (byte_req) begin
        if (!cur_valid) begin
          nxt_tx = IDLE_CH;
        end else if (cur_eop && !end_sent) begin
          nxt_tx       = END_CH;
          nxt_end_sent = 1'b1;
        end else if (pkt_rsvd || link_rsvd) begin
          nxt_tx    = pkt_rsvd ? PKT_ESC_CH : LINK_ESC_CH;
          nxt_phase = PH_ESCB;
        end else begin
          nxt_tx       = cur_data;
          release_o    = 1'b1;
          nxt_end_sent = 1'b0;
          nxt_phase    = cur_eop ? PH_IDLE : PH_BODY;
        end
      end
      PH_ESCB: if (byte_req) begin
        nxt_tx       = cur_data ^ FLIP_MASK;
        release_o    = 1'b1;
        nxt_end_sent = 1'b0;
        nxt_phase    = cur_eop ? PH_IDLE : PH_BODY;
      end
      default: nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      end_sent <= 1'b0;
      tx_q     <= IDLE_CH;
    end else begin
      phase    <= nxt_phase;
      end_sent <= nxt_end_sent;
      tx_q     <= nxt_tx;
    end
  end

  // R8: output only moves on a request edge
  assert_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !byte_req |=> $stable(tx_byte));
  // R2: channel character follows the start character
  assert_chan_R2: assert property (@(posedge clk) disable iff (rst)
    byte_req && phase == PH_CHAN |=> tx_byte == CHAN_CH);
  // R3: the byte after a prefix is never itself a reserved value
  assert_escb_R3: assert property (@(posedge clk) disable iff (rst)
    byte_req && phase == PH_ESCB |=> !is_pkt_rsvd(tx_byte) && !is_link_rsvd(tx_byte));
  // R9: second half of an escape always has its byte still held
  assert_escb_held_R9: assert property (@(posedge clk) disable iff (rst)
    phase == PH_ESCB |-> cur_valid);
  // R7: starved packet sends idle
  assert_starve_R7: assert property (@(posedge clk) disable iff (rst)
    byte_req && phase == PH_BODY && !cur_valid |=> tx_byte == IDLE_CH);
endmodule

// File: rtl/pkt_byte_escaper.sv
module pkt_byte_escaper
  import pbe_pkg::*;
#(
  parameter logic [7:0] CHAN_NUM = 8'h00
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       byte_req,
  output logic [7:0] tx_byte
);
  logic  cur_valid, cur_sop, cur_eop, release_w;
  byte_t cur_data;

  pbe_hold u_hold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .release_i(release_w),
    .in_ready(in_ready), .cur_valid(cur_valid), .cur_data(cur_data),
    .cur_sop(cur_sop), .cur_eop(cur_eop)
  );

  pbe_fsm #(.CHAN_NUM(CHAN_NUM)) u_fsm (
    .clk(clk), .rst(rst), .byte_req(byte_req), .cur_valid(cur_valid),
    .cur_data(cur_data), .cur_sop(cur_sop), .cur_eop(cur_eop),
    .release_o(release_w), .tx_byte(tx_byte)
  );
endmodule

// File: tb/tb_pkt_byte_escaper.sv
`timescale 1ns/1ps
module tb_pkt_byte_escaper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       byte_req = 1'b0;
  logic [7:0] tx_byte;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  pkt_byte_escaper dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .byte_req(byte_req), .tx_byte(tx_byte)
  );

  // {payload byte, expected prefix (0 = sent unchanged)}
  localparam logic [15:0] VEC [10] = '{
    16'h7A7D, 16'h7B7D, 16'h7C7D, 16'h7D7D, 16'h4A4D,
    16'h4D4D, 16'h0000, 16'h5A00, 16'hFF00, 16'h2000
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic pull(input logic [7:0] exp, input string tag);
    @(negedge clk);
    byte_req = 1'b1;
    @(negedge clk);
    byte_req = 1'b0;
    check(tx_byte, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_byte, 8'h4A, "R1 reset tx_byte");
    check({7'd0, in_ready}, 8'h01, "R1 reset in_ready");
    pull(8'h4A, "R7 idle between packets");
    // R8: no request, output held
    repeat (3) @(negedge clk);
    check(tx_byte, 8'h4A, "R8 stable without request");

    // table walk: packet {11, v, 22}
    for (int i = 0; i < 10; i++) begin
      logic [7:0] v, pre;
      v = VEC[i][15:8]; pre = VEC[i][7:0];
      put(8'h11, 1'b1, 1'b0);
      pull(8'h7A, "R2 start");
      pull(8'h7C, "R2 channel char");
      pull(8'h00, "R2 channel number");
      pull(8'h11, "R5 plain byte");
      put(v, 1'b0, 1'b0);
      if (pre != 8'h00) begin
        pull(pre, (pre == 8'h7D) ? "R3 prefix" : "R4 prefix");
        check({7'd0, in_ready}, 8'h00, "R9 held across prefix");
        pull(v ^ 8'h20, (pre == 8'h7D) ? "R3 flipped" : "R4 flipped");
      end else begin
        pull(v, "R5 unchanged");
      end
      put(8'h22, 1'b0, 1'b1);
      pull(8'h7B, "R6 end marker first");
      pull(8'h22, "R6 last byte");
      pull(8'h4A, "R7 idle after packet");
    end

    // R6: last byte reserved, starvation mid packet (R7)
    put(8'h33, 1'b1, 1'b0);
    pull(8'h7A, "R2 start");
    pull(8'h7C, "R2 channel char");
    pull(8'h00, "R2 channel number");
    pull(8'h33, "R5 plain byte");
    pull(8'h4A, "R7 starved inside packet");
    put(8'h7A, 1'b0, 1'b1);
    pull(8'h7B, "R6 end marker before reserved last");
    pull(8'h7D, "R6 last byte prefix");
    pull(8'h5A, "R6 last byte flipped");
    pull(8'h4A, "R7 idle after close");

    // R10: stray byte without start flag
    put(8'h55, 1'b0, 1'b0);
    @(negedge clk);
    check({7'd0, in_ready}, 8'h01, "R10 stray dropped");
    pull(8'h4A, "R10 no output for stray");

    // R11: single-byte packet
    put(8'h4D, 1'b1, 1'b1);
    pull(8'h7A, "R11 start");
    pull(8'h7C, "R11 channel char");
    pull(8'h00, "R11 channel number");
    pull(8'h7B, "R11 end marker");
    pull(8'h4D, "R11 prefix");
    pull(8'h6D, "R11 flipped");
    pull(8'h4A, "R11 idle after");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule